// File: doc/BRIEF.md
# Cell-Level Single-Port Transmit Master

This block is the master end of an 8-bit, cell-mode transmit link that feeds one slave device. A local cell buffer sits behind it and offers a flag that a whole cell is waiting, a flag that the next byte is present, and the byte itself. The block pops bytes one at a time and drives them onto the link. It frames each cell with a one-cycle start-of-cell pulse and marks every valid byte with an active-low enable. When enabled, it also adds a per-byte parity bit.

The slave's cell-available input controls when a cell may begin. A cell that starts from idle needs cell-available high at the clock edge that launches its first byte. While a cell is in flight, the block samples cell-available once, on the edge that launches the fourth byte from the end. If that sample was high, the next cell follows the last byte with no idle cycle. If it was low, at least one idle cycle comes first. If the buffer runs dry in the middle of a cell, the block pauses by raising enable and resumes when data returns. Cell length is a static setting, clamped to the range 16 to 128 bytes.

Top module: `cell_tx_master`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `phy_enb_n`=1, `phy_soc`=0, `phy_data`=0 and `phy_par`=0, and `buf_rd` stays low whatever the other inputs are.
- R2: A cell that does not follow on directly from the previous cell starts only on an edge where `buf_byte_vld`, `buf_cell_rdy` and `phy_clav` are all high.
- R3: Every byte on the link is marked by `phy_enb_n` low. `phy_soc` is high only together with `phy_enb_n` low, and never on two cycles in a row.
- R4: The cell length is `cfg_cell_len` clamped to the range 16 to 128. `phy_soc` marks byte 0 of each cell, and the cell then ends after exactly that many bytes have been presented.
- R5: `phy_clav` is sampled on the edge that launches byte index L-4 of a cell, counting from 0 with length L. If that sample was high and the buffer has the next cell and byte ready, the first byte of the next cell goes out on the cycle right after the last byte, and enable stays low across the boundary.
- R6: If the sample taken at byte L-4 was low, at least one cycle with `phy_enb_n` high follows the last byte of the cell. After that cycle, the next cell needs `phy_clav` high under R2.
- R7: In the middle of a cell, `buf_byte_vld` low makes that cycle an idle cycle: `phy_enb_n` high, `phy_soc` low, no pop. The cell then resumes without regard to `phy_clav`.
- R8: `buf_rd` is high exactly in the cycles in which a byte is taken. Each byte taken appears on `phy_data` after that edge, in buffer order.
- R9: With `cfg_par_en`=1, `phy_par` makes the total count of ones in `phy_data` plus `phy_par` odd when `cfg_par_even`=0, and even when `cfg_par_even`=1. With `cfg_par_en`=0, `phy_par` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock. All outputs change on its rising edge. |
| rst | input | 1 | Synchronous active-high reset. |
| cfg_cell_len | input | LEN_W (8) | Static cell length in bytes, clamped to 16..128. |
| cfg_par_en | input | 1 | Enables generation of the parity bit. |
| cfg_par_even | input | 1 | Selects even parity instead of the default odd parity. |
| buf_cell_rdy | input | 1 | The local buffer holds a whole cell ready to start. |
| buf_byte_vld | input | 1 | The next buffer byte is present on `buf_byte`. |
| buf_byte | input | DATA_W (8) | The next byte from the buffer. |
| buf_rd | output | 1 | Pops the current buffer byte at this clock edge. |
| phy_clav | input | 1 | The slave can accept a whole cell. |
| phy_enb_n | output | 1 | Active-low marker that `phy_data` holds a valid byte. |
| phy_soc | output | 1 | Marks the first byte of a cell. |
| phy_data | output | DATA_W (8) | Link data byte. |
| phy_par | output | 1 | Parity bit for `phy_data`. |

## Verification
The bench uses the default parameters: 8-bit data, a 16..128 byte length range and a sampling lead of four bytes. It does not rebuild the design. Instead it changes the static length between reset runs. The runs cover the shortest and longest lengths, two in-range odd lengths, and one value below the range and one above it to exercise the clamp. Random patterns on cell-available, byte-valid and cell-ready, mixed with runs where these inputs are held high or low, give many cell boundaries with both outcomes of the fourth-from-last sample, as well as mid-cell pauses. Every parity setting is covered.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;

  // What the master does with the byte offered in the current cycle.
  typedef enum logic [1:0] {
    XK_HOLD  = 2'd0,  // nothing taken, link idle
    XK_FRESH = 2'd1,  // first byte of a cell started from idle
    XK_CHAIN = 2'd2,  // first byte of a cell that follows on directly
    XK_BODY  = 2'd3   // any later byte of a cell
  } xfer_kind_e;

  function automatic int clamp_len(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/cell_byte_ctr.sv
module cell_byte_ctr #(
  parameter int LEN_W = 8,
  parameter int LEAD  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] len_eff,
  input  logic             adv,
  output logic             is_first,
  output logic             is_last,
  output logic             is_probe
);

  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] last_idx;
  logic [LEN_W-1:0] probe_idx;

  assign last_idx  = len_eff - LEN_W'(1);
  assign probe_idx = len_eff - LEN_W'(LEAD);

  assign is_first = (idx == '0);
  assign is_last  = (idx == last_idx);
  assign is_probe = (idx == probe_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (adv) begin
      idx <= is_last ? '0 : idx + LEN_W'(1);
    end
  end

endmodule

// File: rtl/cell_start_gate.sv
module cell_start_gate
  import cell_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_cell,
  input  logic       at_probe,
  input  logic       at_last,
  input  logic       slave_clav,
  input  logic       cell_rdy,
  input  logic       byte_vld,
  output logic       take,
  output xfer_kind_e kind
);

  logic chain_ok;   // cell-available as sampled at the probe byte
  logic prev_last;  // the previous edge launched the last byte of a cell

  always_comb begin
    kind = XK_HOLD;
    if (!rst && byte_vld) begin
      if (in_cell) begin
        kind = XK_BODY;
      end else if (cell_rdy) begin
        if (prev_last) begin
          if (chain_ok) kind = XK_CHAIN;
        end else if (slave_clav) begin
          kind = XK_FRESH;
        end
      end
    end
  end

  assign take = (kind != XK_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_ok  <= 1'b0;
      prev_last <= 1'b0;
    end else begin
      prev_last <= take && at_last;
      if (take && at_probe) chain_ok <= slave_clav;
    end
  end

endmodule

// File: rtl/cell_par_gen.sv
module cell_par_gen #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              en,
  input  logic              even,
  output logic              par
);

  logic ones_odd;

  assign ones_odd = ^data;
  assign par      = en & (even ? ones_odd : ~ones_odd);

endmodule

// File: rtl/cell_tx_master.sv
module cell_tx_master
  import cell_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MIN_CELL  = 16,
  parameter int MAX_CELL  = 128,
  parameter int CLAV_LEAD = 4,
  parameter int LEN_W     = $clog2(MAX_CELL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_cell_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              buf_cell_rdy,
  input  logic              buf_byte_vld,
  input  logic [DATA_W-1:0] buf_byte,
  output logic              buf_rd,
  input  logic              phy_clav,
  output logic              phy_enb_n,
  output logic              phy_soc,
  output logic [DATA_W-1:0] phy_data,
  output logic              phy_par
);

  localparam int MIN_ALLOWED = CLAV_LEAD + 1;

  logic [LEN_W-1:0] len_eff;
  logic             is_first;
  logic             is_last;
  logic             is_probe;
  logic             take;
  xfer_kind_e       kind;
  logic             par_bit;

  initial begin
    if (MIN_CELL < MIN_ALLOWED) $error("MIN_CELL must exceed CLAV_LEAD");
  end

  assign len_eff = LEN_W'(clamp_len(int'(cfg_cell_len), MIN_CELL, MAX_CELL));

  cell_byte_ctr #(
    .LEN_W (LEN_W),
    .LEAD  (CLAV_LEAD)
  ) ctr_i (
    .clk      (clk),
    .rst      (rst),
    .len_eff  (len_eff),
    .adv      (take),
    .is_first (is_first),
    .is_last  (is_last),
    .is_probe (is_probe)
  );

  cell_start_gate gate_i (
    .clk        (clk),
    .rst        (rst),
    .in_cell    (!is_first),
    .at_probe   (is_probe),
    .at_last    (is_last),
    .slave_clav (phy_clav),
    .cell_rdy   (buf_cell_rdy),
    .byte_vld   (buf_byte_vld),
    .take       (take),
    .kind       (kind)
  );

  cell_par_gen #(
    .DATA_W (DATA_W)
  ) par_i (
    .data (buf_byte),
    .en   (cfg_par_en),
    .even (cfg_par_even),
    .par  (par_bit)
  );

  assign buf_rd = take;

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_enb_n <= 1'b1;
      phy_soc   <= 1'b0;
      phy_data  <= '0;
      phy_par   <= 1'b0;
    end else if (take) begin
      phy_enb_n <= 1'b0;
      phy_soc   <= (kind == XK_FRESH) || (kind == XK_CHAIN);
      phy_data  <= buf_byte;
      phy_par   <= par_bit;
    end else begin
      phy_enb_n <= 1'b1;
      phy_soc   <= 1'b0;
    end
  end

endmodule

// File: rtl/cell_tx_master_chk.sv
module cell_tx_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_par_en,
  input logic              cfg_par_even,
  input logic              buf_rd,
  input logic              phy_clav,
  input logic              phy_enb_n,
  input logic              phy_soc,
  input logic [DATA_W-1:0] phy_data,
  input logic              phy_par
);

  // R3
  soc_with_enb_chk: assert property (@(posedge clk) disable iff (rst)
    phy_soc |-> !phy_enb_n);

  // R3
  soc_single_chk: assert property (@(posedge clk) disable iff (rst)
    phy_soc |=> !phy_soc);

  // R8
  pop_then_drive_chk: assert property (@(posedge clk) disable iff (rst)
    buf_rd |=> !phy_enb_n);

  // R8
  no_pop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !buf_rd |=> (phy_enb_n && !phy_soc));

  // R2
  fresh_start_clav_chk: assert property (@(posedge clk) disable iff (rst)
    (phy_soc && $past(phy_enb_n)) |-> $past(phy_clav));

  // R9
  data_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (!phy_enb_n && cfg_par_en) |->
      (phy_par == (cfg_par_even ? (^phy_data) : ~(^phy_data))));

  // R9
  parity_off_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_par_en |-> !phy_par);

endmodule

bind cell_tx_master cell_tx_master_chk #(.DATA_W(DATA_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cfg_par_en   (cfg_par_en),
  .cfg_par_even (cfg_par_even),
  .buf_rd       (buf_rd),
  .phy_clav     (phy_clav),
  .phy_enb_n    (phy_enb_n),
  .phy_soc      (phy_soc),
  .phy_data     (phy_data),
  .phy_par      (phy_par)
);

// File: tb/cell_tx_master_test.sv
`timescale 1ns/1ps
module cell_tx_master_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_cell_len = 8'd16;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       buf_cell_rdy = 1'b0;
  logic       buf_byte_vld = 1'b0;
  logic [7:0] buf_byte = 8'd0;
  logic       buf_rd;
  logic       phy_clav = 1'b0;
  logic       phy_enb_n;
  logic       phy_soc;
  logic [7:0] phy_data;
  logic       phy_par;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int ptr = 0;
  int soc_seen = 0;
  int gaps_seen = 0;
  int chains_seen = 0;

  always #2.5 clk = ~clk;

  cell_tx_master uut (
    .clk          (clk),
    .rst          (rst),
    .cfg_cell_len (cfg_cell_len),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_even (cfg_par_even),
    .buf_cell_rdy (buf_cell_rdy),
    .buf_byte_vld (buf_byte_vld),
    .buf_byte     (buf_byte),
    .buf_rd       (buf_rd),
    .phy_clav     (phy_clav),
    .phy_enb_n    (phy_enb_n),
    .phy_soc      (phy_soc),
    .phy_data     (phy_data),
    .phy_par      (phy_par)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [7:0] src(input int k);
    return 8'((k * 37 + (k >> 3) + 5) & 255);
  endfunction

  function automatic bit pick(input int mode, input bit rnd);
    if (mode == 0) return 1'b1;
    if (mode == 2) return 1'b0;
    return rnd;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // len: raw setting; cm/vm/rm: 0 = always high, 1 = random, 2 = always low
  task automatic run_case(input int len, input bit pe, input bit pev,
                          input int cm, input int vm, input int rm, input int cycles);
    int  lim;
    int  pos;
    bit  cont_b;
    bit  last_b;
    bit  exp_take;
    bit  clav_d;
    logic exp_par;
    string tag;
    lim = (len < 16) ? 16 : ((len > 128) ? 128 : len);
    @(negedge clk);
    rst = 1'b1;
    cfg_cell_len = 8'(len);
    cfg_par_en = pe;
    cfg_par_even = pev;
    buf_cell_rdy = 1'b1;
    buf_byte_vld = 1'b1;
    phy_clav = 1'b1;
    buf_byte = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(buf_rd == 1'b0, "R1 buf_rd in reset", buf_rd, 0);
      @(posedge clk); #1;
      chk(phy_enb_n == 1'b1 && phy_soc == 1'b0, "R1 enb/soc in reset",
          {phy_enb_n, phy_soc}, 2);
      chk(phy_data == 8'd0 && phy_par == 1'b0, "R1 data/par in reset",
          {phy_data, phy_par}, 0);
      @(negedge clk);
    end
    rst = 1'b0;
    pos = 0;
    cont_b = 1'b0;
    last_b = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      if (c != 0) @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      phy_clav     = pick(cm, lfsr[3] | lfsr[4]);
      buf_byte_vld = pick(vm, lfsr[0] | lfsr[1] | lfsr[9]);
      buf_cell_rdy = pick(rm, lfsr[6] | lfsr[7]);
      buf_byte     = src(ptr);
      clav_d       = phy_clav;
      if (pos != 0) tag = "R7 mid-cell take";
      else if (last_b) tag = cont_b ? "R5 chained start" : "R6 forced gap";
      else tag = "R2 fresh start";
      exp_take = buf_byte_vld &&
                 ((pos != 0) || (buf_cell_rdy && (last_b ? cont_b : clav_d)));
      #1;
      chk(buf_rd == exp_take, tag, buf_rd, exp_take);
      @(posedge clk); #1;
      if (exp_take) begin
        exp_par = pe ? (pev ? (^src(ptr)) : ~(^src(ptr))) : 1'b0;
        chk(phy_enb_n == 1'b0, "R3 enable low on byte", phy_enb_n, 0);
        chk(phy_soc == (pos == 0), "R4 soc on byte 0 only", phy_soc, pos == 0);
        chk(phy_data == src(ptr), "R8 byte order", phy_data, src(ptr));
        chk(phy_par == exp_par, "R9 parity", phy_par, exp_par);
        if (pos == 0) begin
          soc_seen++;
          if (last_b) chains_seen++;
        end
        if (pos == lim - 4) cont_b = clav_d;
        last_b = (pos == lim - 1);
        pos = (pos == lim - 1) ? 0 : pos + 1;
        ptr++;
      end else begin
        chk(phy_enb_n == 1'b1 && phy_soc == 1'b0, "R7 idle cycle",
            {phy_enb_n, phy_soc}, 2);
        if (last_b && !cont_b) gaps_seen++;
        last_b = 1'b0;
      end
    end
  endtask

  initial begin
    run_case(16,  1'b1, 1'b0, 0, 0, 0, 200);
    run_case(17,  1'b1, 1'b1, 1, 0, 0, 600);
    run_case(20,  1'b0, 1'b0, 0, 1, 0, 600);
    run_case(128, 1'b1, 1'b0, 1, 1, 1, 1500);
    run_case(5,   1'b1, 1'b1, 1, 1, 1, 600);
    run_case(200, 1'b1, 1'b0, 0, 0, 0, 400);
    run_case(16,  1'b1, 1'b0, 2, 0, 0, 100);
    run_case(33,  1'b0, 1'b1, 1, 0, 1, 800);
    // coverage of the boundary outcomes (R5 chained, R6 gap)
    chk(chains_seen > 0, "R5 chained boundary seen", chains_seen, 1);
    chk(gaps_seen > 0, "R6 forced gap seen", gaps_seen, 1);
    chk(soc_seen > 20, "R4 cells framed", soc_seen, 21);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule